// File: doc/BRIEF.md
# Frame Start Keeper

This block keeps a peripheral's notion of bus frame timing alive. An upstream packet decoder hands it one pulse per decoded start-of-frame token, together with a flag that says whether the token arrived intact and the 11-bit frame number that the token carried. On every intact token the block captures the frame number into a register and raises a one-clock frame strobe.

A local period counter advances on a 12 MHz enable and measures the time since the most recent frame start. If a frame start goes missing or arrives damaged, the counter runs past the nominal 12000-tick period plus a small margin. The block then raises a substitute frame strobe of its own and advances the stored frame number by one, wrapping to zero at the top of its range. While tokens keep failing to arrive, substitute strobes follow at the nominal period. Each intact token restarts the counter, so the local timing tracks the host.

A processor can read the frame number output directly and use it as a time stamp.

Top module: `frame_tick_keeper`

## Requirements
- R1: After reset both strobes are low and the frame number is 0. No substitute strobe is produced until the first intact frame start has been seen, however many enable ticks pass.
- R2: An event with `sof_seen`=1 and `sof_good`=1 sampled at a clock edge makes `frame_num` equal `sof_num` and raises `sof_pulse` for one clock, both starting right after that edge.
- R3: After an intact frame start, `psof_pulse` rises right after the edge that samples the (PERIOD+MARGIN)-th enabled tick, provided no intact frame start came in between. It does not rise on any earlier tick.
- R4: An event with `sof_seen`=1 and `sof_good`=0 is ignored. No strobe follows, `frame_num` keeps its value and the period count is not restarted.
- R5: Each substitute strobe advances `frame_num` by one, modulo 2^FNUM_W (2047 wraps to 0 at the default width).
- R6: After a substitute strobe, and with still no intact frame start, the next substitute strobe follows PERIOD enabled ticks later.
- R7: An intact frame start restarts the period count, so the next timeout is measured from it.
- R8: Each strobe is one clock wide, and the two strobes are never high in the same cycle. When an intact frame start coincides with a timeout, only `sof_pulse` is raised and `frame_num` takes `sof_num`.
- R9: The period count advances only on cycles with `tick_en`=1. Clock cycles without the enable never cause a timeout.
- R10: `frame_num` changes only in a cycle in which one of the two strobes is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | 12 MHz timing enable, one clock wide per tick |
| sof_seen | input | 1 | A decoded frame-start token is presented this cycle |
| sof_good | input | 1 | The presented token passed its integrity checks |
| sof_num | input | FNUM_W | Frame number carried by the token |
| sof_pulse | output | 1 | One-clock strobe for an intact frame start |
| psof_pulse | output | 1 | One-clock substitute strobe for a missing frame start |
| frame_num | output | FNUM_W | Stored frame number |

## Verification
The bench builds the block with FNUM_W=4, PERIOD=10 and MARGIN=3, so one full timeout takes 13 ticks and the frame number wraps after 16 values. At this size the bench can latch every frame number value and check each substitute increment, including the wrap from 15 to 0. The reduced size also lets it measure every timeout window tick by tick. Sparse enable patterns, a damaged token inside a window, and an intact token that lands on the timeout tick are all checked against tick counts computed in the bench.

// File: rtl/fsof_pkg.sv
package fsof_pkg;

   // Frame event chosen in a given cycle
   typedef enum logic [1:0] {
      EVT_IDLE   = 2'd0,
      EVT_HOST   = 2'd1,
      EVT_PSEUDO = 2'd2
   } frame_evt_t;

endpackage

// File: rtl/fsof_window.sv
// Period counter: counts enabled ticks since the last frame start and
// flags a timeout once the host has been seen at least once.
module fsof_window #(
   parameter int PERIOD = 12000,
   parameter int MARGIN = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic host_sof,
   output logic expire
);
   localparam int LIMIT = PERIOD + MARGIN;
   localparam int CNT_W = $clog2(LIMIT + 1);

   logic [CNT_W-1:0] cnt;
   logic             armed;

   // Timeout on the LIMIT-th enabled tick counted from the last restart
   assign expire = armed && tick_en && (cnt == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (host_sof) begin
         cnt   <= '0;
         armed <= 1'b1;
      end else if (expire) begin
         // Later substitutes follow at the bare period
         cnt   <= CNT_W'(MARGIN);
      end else if (tick_en && armed) begin
         cnt   <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fsof_number.sv
// Stored frame number: loads on a host frame start, steps on a substitute.
module fsof_number
   import fsof_pkg::*;
#(
   parameter int FNUM_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  frame_evt_t        evt,
   input  logic [FNUM_W-1:0] host_num,
   output logic [FNUM_W-1:0] num
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num <= '0;
      end else begin
         case (evt)
            EVT_HOST:   num <= host_num;
            EVT_PSEUDO: num <= num + 1'b1;   // natural wrap at 2^FNUM_W
            default:    num <= num;
         endcase
      end
   end

endmodule

// File: rtl/fsof_strobe.sv
// Registered one-clock strobes derived from the chosen event.
module fsof_strobe
   import fsof_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  frame_evt_t evt,
   output logic       host_stb,
   output logic       pseudo_stb
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_stb   <= 1'b0;
         pseudo_stb <= 1'b0;
      end else begin
         host_stb   <= (evt == EVT_HOST);
         pseudo_stb <= (evt == EVT_PSEUDO);
      end
   end

endmodule

// File: rtl/frame_tick_keeper.sv
// Frame start keeper: latches host frame numbers and fills in missing
// frame starts with substitute strobes.
module frame_tick_keeper
   import fsof_pkg::*;
#(
   parameter int FNUM_W = 11,
   parameter int PERIOD = 12000,
   parameter int MARGIN = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              sof_seen,
   input  logic              sof_good,
   input  logic [FNUM_W-1:0] sof_num,
   output logic              sof_pulse,
   output logic              psof_pulse,
   output logic [FNUM_W-1:0] frame_num
);

   initial begin
      if (FNUM_W < 1)  $error("frame_tick_keeper: FNUM_W must be at least 1");
      if (PERIOD < 2)  $error("frame_tick_keeper: PERIOD must be at least 2");
      if (MARGIN < 0)  $error("frame_tick_keeper: MARGIN must not be negative");
   end

   logic       host_sof;
   logic       expire;
   frame_evt_t evt;

   assign host_sof = sof_seen && sof_good;

   // An intact frame start outranks a timeout in the same cycle
   always_comb begin
      if (host_sof)    evt = EVT_HOST;
      else if (expire) evt = EVT_PSEUDO;
      else             evt = EVT_IDLE;
   end

   fsof_window #(
      .PERIOD (PERIOD),
      .MARGIN (MARGIN)
   ) u_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .host_sof (host_sof),
      .expire   (expire)
   );

   fsof_number #(
      .FNUM_W (FNUM_W)
   ) u_number (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .host_num (sof_num),
      .num      (frame_num)
   );

   fsof_strobe u_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .host_stb   (sof_pulse),
      .pseudo_stb (psof_pulse)
   );

endmodule

// File: rtl/fsof_checker.sv
module fsof_checker #(
   parameter int FNUM_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sof_seen,
   input logic              sof_good,
   input logic [FNUM_W-1:0] sof_num,
   input logic              sof_pulse,
   input logic              psof_pulse,
   input logic [FNUM_W-1:0] frame_num
);

   AST_HOST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_seen && sof_good) |=> (sof_pulse && frame_num == $past(sof_num))); // R2

   AST_BAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_seen && !sof_good) |=> !sof_pulse); // R4

   AST_PSEUDO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      psof_pulse |-> frame_num == FNUM_W'($past(frame_num) + 1'b1)); // R5

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(sof_pulse && psof_pulse)); // R8

   AST_PSEUDO_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      psof_pulse |=> !psof_pulse); // R8

   AST_NUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof_pulse && !psof_pulse) |-> $stable(frame_num)); // R10

endmodule

bind frame_tick_keeper fsof_checker #(.FNUM_W(FNUM_W)) u_fsof_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .sof_seen   (sof_seen),
   .sof_good   (sof_good),
   .sof_num    (sof_num),
   .sof_pulse  (sof_pulse),
   .psof_pulse (psof_pulse),
   .frame_num  (frame_num)
);

// File: tb/frame_tick_keeper_test.sv
module frame_tick_keeper_test;

   localparam int CLK_P  = 10;
   localparam int FW     = 4;
   localparam int PER    = 10;
   localparam int MAR    = 3;
   localparam int LIM    = PER + MAR;
   localparam int NVALS  = 1 << FW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          sof_seen = 1'b0;
   logic          sof_good = 1'b0;
   logic [FW-1:0] sof_num = '0;
   logic          sof_pulse;
   logic          psof_pulse;
   logic [FW-1:0] frame_num;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   frame_tick_keeper #(.FNUM_W(FW), .PERIOD(PER), .MARGIN(MAR)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .sof_seen   (sof_seen),
      .sof_good   (sof_good),
      .sof_num    (sof_num),
      .sof_pulse  (sof_pulse),
      .psof_pulse (psof_pulse),
      .frame_num  (frame_num)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock with the given inputs; returns 1 ns after the edge
   task automatic cyc(input logic tk, input logic sv, input logic gd, input int n);
      tick_en  = tk;
      sof_seen = sv;
      sof_good = gd;
      sof_num  = FW'(n);
      @(posedge clk);
      #1;
      tick_en  = 1'b0;
      sof_seen = 1'b0;
      sof_good = 1'b0;
   endtask

   // Intact frame start carrying n (also an enabled tick when tk=1)
   task automatic host(input int n, input logic tk, input string req);
      cyc(tk, 1'b1, 1'b1, n);
      check({req, " sof_pulse"}, sof_pulse, 1);
      check({req, " psof_pulse"}, psof_pulse, 0);
      check({req, " frame_num"}, frame_num, n % NVALS);
   endtask

   // n enabled ticks with no strobe expected and frame number held
   task automatic quiet(input int n, input int exp_num, input string req);
      for (int i = 0; i < n; i++) begin
         cyc(1'b1, 1'b0, 1'b0, 0);
         check({req, " no psof"}, psof_pulse, 0);
         check({req, " no sof"}, sof_pulse, 0);
         check("R10 frame_num held", frame_num, exp_num);
      end
   endtask

   // One enabled tick on which a substitute strobe is expected
   task automatic expect_pseudo(input int exp_num, input string req);
      cyc(1'b1, 1'b0, 1'b0, 0);
      check({req, " psof_pulse"}, psof_pulse, 1);
      check({req, " sof_pulse low"}, sof_pulse, 0);
      check("R5 stepped frame_num", frame_num, exp_num % NVALS);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seen;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 sof_pulse at reset", sof_pulse, 0);
      check("R1 psof_pulse at reset", psof_pulse, 0);
      check("R1 frame_num at reset", frame_num, 0);
      rst_n = 1'b1;
      // R1: unarmed until an intact frame start
      quiet(4 * LIM, 0, "R1 unarmed");

      // R2, R3, R5, R6, R8: first timeout after LIM ticks, then every PER
      host(5, 1'b1, "R2 host latch");
      quiet(LIM - 1, 5, "R3 before timeout");
      expect_pseudo(6, "R3 first timeout");
      quiet(PER - 1, 6, "R6 / R8 after pseudo");
      expect_pseudo(7, "R6 repeat period");
      quiet(PER - 1, 7, "R6 second gap");
      expect_pseudo(8, "R6 repeat period again");

      // R5: sweep every value, substitute increment with wrap
      for (int v = 0; v < NVALS; v++) begin
         host(v, 1'b1, "R2 sweep latch");
         quiet(LIM - 1, v, "R3 sweep window");
         expect_pseudo(v + 1, "R5 sweep step");
      end
      // R5: wrap across a run of substitutes
      host(NVALS - 2, 1'b1, "R2 latch near top");
      quiet(LIM - 1, NVALS - 2, "R3 near top");
      expect_pseudo(NVALS - 1, "R5 to top");
      quiet(PER - 1, NVALS - 1, "R6 at top");
      expect_pseudo(0, "R5 wrap to zero");

      // R4: damaged token ignored and does not restart the count
      host(3, 1'b1, "R2 before bad token");
      quiet(5, 3, "R4 lead-in");
      cyc(1'b1, 1'b1, 1'b0, 9);
      check("R4 bad token no sof_pulse", sof_pulse, 0);
      check("R4 bad token no psof_pulse", psof_pulse, 0);
      check("R4 bad token frame_num", frame_num, 3);
      quiet(LIM - 7, 3, "R4 count not restarted");
      expect_pseudo(4, "R4 timeout on original schedule");

      // R7: intact frame start mid-window restarts the count
      host(2, 1'b1, "R7 first start");
      quiet(8, 2, "R7 partial window");
      host(7, 1'b1, "R7 restart");
      quiet(LIM - 1, 7, "R7 full window after restart");
      expect_pseudo(8, "R7 timeout from restart");

      // R9: sparse enable, plus long stretch without any enable
      host(1, 1'b1, "R9 start");
      repeat (50) begin
         cyc(1'b0, 1'b0, 1'b0, 0);
         check("R9 no tick no psof", psof_pulse, 0);
      end
      seen = 0;
      for (int i = 0; seen < LIM; i++) begin
         logic tk;
         tk = (i % 3 == 2);
         if (tk) seen++;
         cyc(tk, 1'b0, 1'b0, 0);
         check("R9 psof only on LIM-th tick", psof_pulse, (seen == LIM && tk) ? 1 : 0);
      end
      check("R9 stepped frame_num", frame_num, 2);

      // R8: intact start on the timeout tick wins
      host(4, 1'b1, "R8 start");
      quiet(LIM - 1, 4, "R8 window");
      host(11, 1'b1, "R8 coincident host wins");
      quiet(LIM - 1, 11, "R8 window after coincidence");
      expect_pseudo(12, "R8 later timeout");
      cyc(1'b0, 1'b0, 1'b0, 0);
      check("R8 psof one clock wide", psof_pulse, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule